// File: doc/BRIEF.md
# Converter Output-Path Setup Sequencer

This block brings up the output interface and the decimation path of a high-speed data converter. When it sees a start pulse, it captures four setting inputs: the output lane format, the sample resolution, the decimation style, and the filter/mixer settings. It then works through a fixed, ordered series of register writes whose contents depend on those settings. Writes that do not apply to the chosen combination are skipped. The one timed pause in the series is the settling time of a fuse-style bit-map load. That load would erase any earlier write, so only the bit-map select write may come before it.

Each write goes out on a single address/data port with a request/acknowledge handshake, and only one write is in flight at a time. When the series ends, the block raises `done`. If the requested combination cannot be configured, the block raises `cfg_err` and issues no writes. The wait length is derived from a clock-frequency parameter, so a bench can shorten it.

Top module: `adc_outcfg_seq`

## Requirements
- R1: A start with the lane format 0 (DDR) and resolution code 2 or 3, or with decimation code 3, raises `cfg_err` on the next cycle. In that case the block issues no write, leaves `done` low and leaves `busy` low.
- R2: The first write goes to address 0x07. For DDR (lane code 0) the value is 0xA9 at resolution code 0 and 0x4B at code 1. For two-lane (code 1) it is 0x2B at codes 0 and 2, and 0x4B at codes 1 and 3. For one-lane (code 2) it is 0x6C and for half-lane (code 3) it is 0x8D, at every resolution.
- R3: The second write is 0x01 to address 0x13. A pause of at least CLK_FREQ_HZ*WAIT_US/1e6 cycles follows, and then 0x00 is written to 0x13. No other write lies between these writes or before them.
- R4: For any serial format (lane code not 0), 0x10 goes to 0x18 and 0x50 goes to 0x1F. For DDR both writes are skipped.
- R5: For serial formats, 0x19 receives frame-source in bit 7, frame-divide in bit 4 and frame-toggle in bit 0. These are 0,1,0 for two-lane with no complex decimation; 0,0,0 for one-lane or half-lane with no complex decimation; 1,0,0 for complex on two-lane or one-lane; and 0,0,1 for complex on half-lane.
- R6: Address 0x1B always receives the resolution code (0=14, 1=16, 2=18, 3=20 bits) in bits 5..3, with the other bits zero.
- R7: A 20-bit frame pattern is written as three writes: bits 7..0 to 0x20, bits 15..8 to 0x21, and bits 19..16 to 0x22 (upper nibble zero). For real decimation (code 1) on one-lane, the pattern is 0xFE000, 0xFF000, 0xFF800 or 0xFFC00 for resolution codes 0..3. For complex decimation (code 2) on two-lane or one-lane, it is 0xFFFFF. Otherwise the three writes are skipped.
- R8: Address 0x24 receives 0x01 when decimation is real or complex and 0x00 for bypass (code 0). Address 0x25 always receives the captured `dec_cfg` byte.
- R9: Only for complex decimation, the 32-bit `nco_word` is written least-significant byte first to 0x2A..0x2D, and then again to 0x31..0x34.
- R10: For real or complex decimation, the same byte is written to 0x27 and then to 0x2E. It holds order-swap in bit 4 and Q-delay in bit 3. For complex decimation these bits are 1,0 on two-lane, 0,1 on one-lane and 1,1 on half-lane. For real decimation, and for complex on DDR, both bits are 0. For bypass the two writes are skipped.
- R11: The series ends with three writes to 0x26: {gain,0}, then {gain,1}, then {gain,0}, where bit 0 is the mixer reset. After these, `done` rises and `busy` falls.
- R12: While `wr_req` is high and `wr_ack` is low, `wr_addr` and `wr_data` hold steady. After an acknowledged cycle, `wr_req` is low for at least one cycle.
- R13: A start pulse while `busy` is high changes nothing, including the write log and `cfg_err`. `done` stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the series |
| lane_mode | input | 2 | 0 DDR, 1 two-lane, 2 one-lane, 3 half-lane |
| res_code | input | 2 | 0=14, 1=16, 2=18, 3=20 bits |
| dec_mode | input | 2 | 0 bypass, 1 real, 2 complex, 3 invalid |
| dec_cfg | input | 8 | Byte for the decimation configuration write |
| nco_word | input | 32 | Mixer frequency word |
| mix_gain | input | 7 | Mixer gain field |
| wr_req | output | 1 | Write request |
| wr_addr | output | 8 | Write address |
| wr_data | output | 8 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | Series in progress |
| done | output | 1 | Series finished |
| cfg_err | output | 1 | Unsupported combination |

## Verification
A corrupted step index or captured setting is visible at the write port itself. It shows up as a missing, extra or reordered write, or as a wrong byte, on the very write where the fault occurs. For that reason the bench compares complete write logs in order for every legal combination. If the pause counter is wrong, the gap between the two 0x13 writes changes, and that gap is measured in cycles. A fault in the handshake shows within one cycle as an address or data change while a request is pending.

// File: rtl/outcfg_pkg.sv
package outcfg_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_STEPS = 26;
  localparam int IDX_W     = $clog2(NUM_STEPS + 1);

  typedef enum logic [1:0] {ST_SKIP, ST_WRITE, ST_PAUSE, ST_END} stepkind_t;

  function automatic logic combo_bad(input logic [1:0] lane, input logic [1:0] res,
                                     input logic [1:0] dec);
    return (dec == 2'd3) || (lane == 2'd0 && res[1]);
  endfunction
endpackage

// File: rtl/outcfg_step.sv
module outcfg_step
  import outcfg_pkg::*;
#(
  parameter int NCO_W = 32
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        lane,
  input  logic [1:0]        res,
  input  logic [1:0]        dec,
  input  logic [BYTE_W-1:0] dcfg,
  input  logic [NCO_W-1:0]  nco,
  input  logic [6:0]        gain,
  output stepkind_t         kind,
  output logic [BYTE_W-1:0] addr,
  output logic [BYTE_W-1:0] data
);
  logic serial, cpx, anydec, pat_en;
  logic [BYTE_W-1:0] bitmap, fclk, opq, ncob;
  logic [19:0] pat;
  logic [1:0]  k;

  always_comb begin
    serial = (lane != 2'd0);
    cpx    = (dec == 2'd2);
    anydec = (dec == 2'd1) || cpx;
    unique case (lane)
      2'd0:    bitmap = res[0] ? 8'h4B : 8'hA9;
      2'd1:    bitmap = res[0] ? 8'h4B : 8'h2B;
      2'd2:    bitmap = 8'h6C;
      default: bitmap = 8'h8D;
    endcase
    fclk = {cpx && (lane != 2'd3), 2'b00, !cpx && (lane == 2'd1), 3'b000, cpx && (lane == 2'd3)};
    pat_en = ((dec == 2'd1) && lane == 2'd2) || (cpx && (lane == 2'd1 || lane == 2'd2));
    if (cpx) pat = 20'hFFFFF;
    else begin
      unique case (res)
        2'd0:    pat = 20'hFE000;
        2'd1:    pat = 20'hFF000;
        2'd2:    pat = 20'hFF800;
        default: pat = 20'hFFC00;
      endcase
    end
    opq = 8'h00;
    if (cpx) begin
      unique case (lane)
        2'd1:    opq = 8'h10;
        2'd2:    opq = 8'h08;
        2'd3:    opq = 8'h18;
        default: opq = 8'h00;
      endcase
    end
    k    = 2'(idx - IDX_W'(13));
    if (idx >= IDX_W'(17)) k = 2'(idx - IDX_W'(17));
    ncob = BYTE_W'(nco >> {k, 3'b000});
  end

  always_comb begin
    kind = ST_WRITE;
    addr = '0;
    data = '0;
    case (idx) inside
      5'd0:  begin addr = 8'h07; data = bitmap; end
      5'd1:  begin addr = 8'h13; data = 8'h01; end
      5'd2:  kind = ST_PAUSE;
      5'd3:  begin addr = 8'h13; data = 8'h00; end
      5'd4:  begin addr = 8'h18; data = 8'h10; if (!serial) kind = ST_SKIP; end
      5'd5:  begin addr = 8'h19; data = fclk;  if (!serial) kind = ST_SKIP; end
      5'd6:  begin addr = 8'h1B; data = {2'b00, res, 3'b000}; end
      5'd7:  begin addr = 8'h1F; data = 8'h50; if (!serial) kind = ST_SKIP; end
      5'd8:  begin addr = 8'h20; data = pat[7:0];  if (!pat_en) kind = ST_SKIP; end
      5'd9:  begin addr = 8'h21; data = pat[15:8]; if (!pat_en) kind = ST_SKIP; end
      5'd10: begin addr = 8'h22; data = {4'b0000, pat[19:16]}; if (!pat_en) kind = ST_SKIP; end
      5'd11: begin addr = 8'h24; data = {7'b0, anydec}; end
      5'd12: begin addr = 8'h25; data = dcfg; end
      [5'd13:5'd16]: begin addr = 8'h2A + 8'(k); data = ncob; if (!cpx) kind = ST_SKIP; end
      [5'd17:5'd20]: begin addr = 8'h31 + 8'(k); data = ncob; if (!cpx) kind = ST_SKIP; end
      5'd21: begin addr = 8'h27; data = opq; if (!anydec) kind = ST_SKIP; end
      5'd22: begin addr = 8'h2E; data = opq; if (!anydec) kind = ST_SKIP; end
      5'd23: begin addr = 8'h26; data = {gain, 1'b0}; end
      5'd24: begin addr = 8'h26; data = {gain, 1'b1}; end
      5'd25: begin addr = 8'h26; data = {gain, 1'b0}; end
      default: kind = ST_END;
    endcase
  end
endmodule

// File: rtl/outcfg_timer.sv
module outcfg_timer #(
  parameter longint unsigned CYCLES = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= CW'(CYCLES - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0);

  assert_load_runs_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> run && !expired || (CYCLES == 1));
endmodule

// File: rtl/adc_outcfg_seq.sv
module adc_outcfg_seq
  import outcfg_pkg::*;
#(
  parameter longint unsigned CLK_FREQ_HZ = 100000000,
  parameter longint unsigned WAIT_US     = 1000,
  parameter int              NCO_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        lane_mode,
  input  logic [1:0]        res_code,
  input  logic [1:0]        dec_mode,
  input  logic [BYTE_W-1:0] dec_cfg,
  input  logic [NCO_W-1:0]  nco_word,
  input  logic [6:0]        mix_gain,
  output logic              wr_req,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              busy,
  output logic              done,
  output logic              cfg_err
);
  localparam longint unsigned RAW_CYC  = (CLK_FREQ_HZ * WAIT_US) / 64'd1000000;
  localparam longint unsigned WAIT_CYC = (RAW_CYC == 0) ? 64'd1 : RAW_CYC;

  typedef enum logic [1:0] {S_IDLE, S_NEXT, S_REQ, S_WAIT} state_t;
  state_t st;

  logic [IDX_W-1:0]  idx;
  logic [1:0]        lane_q, res_q, dec_q;
  logic [BYTE_W-1:0] dcfg_q;
  logic [NCO_W-1:0]  nco_q;
  logic [6:0]        gain_q;
  stepkind_t         kind;
  logic [BYTE_W-1:0] s_addr, s_data;
  logic              tmr_load, tmr_exp;

  outcfg_step #(.NCO_W(NCO_W)) u_step (
    .idx(idx), .lane(lane_q), .res(res_q), .dec(dec_q), .dcfg(dcfg_q),
    .nco(nco_q), .gain(gain_q), .kind(kind), .addr(s_addr), .data(s_data)
  );

  assign tmr_load = (st == S_NEXT) && (kind == ST_PAUSE);

  outcfg_timer #(.CYCLES(WAIT_CYC)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      idx     <= '0;
      wr_req  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      cfg_err <= 1'b0;
      lane_q  <= '0;
      res_q   <= '0;
      dec_q   <= '0;
      dcfg_q  <= '0;
      nco_q   <= '0;
      gain_q  <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          lane_q <= lane_mode;
          res_q  <= res_code;
          dec_q  <= dec_mode;
          dcfg_q <= dec_cfg;
          nco_q  <= nco_word;
          gain_q <= mix_gain;
          done   <= 1'b0;
          idx    <= '0;
          if (combo_bad(lane_mode, res_code, dec_mode)) begin
            cfg_err <= 1'b1;
          end else begin
            cfg_err <= 1'b0;
            busy    <= 1'b1;
            st      <= S_NEXT;
          end
        end
        S_NEXT: begin
          unique case (kind)
            ST_END: begin
              busy <= 1'b0;
              done <= 1'b1;
              st   <= S_IDLE;
            end
            ST_PAUSE: st  <= S_WAIT;
            ST_SKIP:  idx <= idx + 1'b1;
            default: begin
              wr_addr <= s_addr;
              wr_data <= s_data;
              wr_req  <= 1'b1;
              st      <= S_REQ;
            end
          endcase
        end
        S_REQ: if (wr_ack) begin
          wr_req <= 1'b0;
          idx    <= idx + 1'b1;
          st     <= S_NEXT;
        end
        default: if (tmr_exp) begin
          idx <= idx + 1'b1;
          st  <= S_NEXT;
        end
      endcase
    end
  end

  assert_hold_req_R12: assert property (@(posedge clk) disable iff (rst)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));
  assert_drop_after_ack_R12: assert property (@(posedge clk) disable iff (rst)
    wr_req && wr_ack |=> !wr_req);
  assert_err_silent_R1: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !wr_req && !busy);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !wr_req);
  assert_quiet_pause_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT) |-> !wr_req);
  assert_busy_hold_R13: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> busy || done);
endmodule

// File: tb/adc_outcfg_seq_test.sv
module adc_outcfg_seq_test;
  localparam longint unsigned FREQ = 100000;
  localparam int WAITC = 100;

  logic clk = 0, rst = 1, start = 0, wr_ack = 0;
  logic [1:0] lane_mode = 0, res_code = 0, dec_mode = 0;
  logic [7:0] dec_cfg = 0;
  logic [31:0] nco_word = 0;
  logic [6:0] mix_gain = 0;
  logic wr_req, busy, done, cfg_err;
  logic [7:0] wr_addr, wr_data;

  int checks = 0, failures = 0, cyc = 0, nlog = 0, nexp = 0;
  logic [7:0] la [0:63];
  logic [7:0] ld [0:63];
  int         lt [0:63];
  logic [7:0] ea [0:63];
  logic [7:0] ed [0:63];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  adc_outcfg_seq #(.CLK_FREQ_HZ(FREQ)) uut (
    .clk(clk), .rst(rst), .start(start), .lane_mode(lane_mode), .res_code(res_code),
    .dec_mode(dec_mode), .dec_cfg(dec_cfg), .nco_word(nco_word), .mix_gain(mix_gain),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  always @(negedge clk) begin
    if (wr_ack) wr_ack <= 1'b0;
    else if (wr_req) begin
      if (nlog < 64) begin
        la[nlog] = wr_addr; ld[nlog] = wr_data; lt[nlog] = cyc;
      end
      nlog++;
      wr_ack <= 1'b1;
    end
  end

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h07: return "R2";
      8'h13: return "R3";
      8'h18, 8'h1F: return "R4";
      8'h19: return "R5";
      8'h1B: return "R6";
      8'h20, 8'h21, 8'h22: return "R7";
      8'h24, 8'h25: return "R8";
      8'h27, 8'h2E: return "R10";
      8'h26: return "R11";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] a, input logic [7:0] d);
    ea[nexp] = a; ed[nexp] = d; nexp++;
  endtask

  task automatic build_exp(input int ln, input int rs, input int dc, input logic [7:0] cfg,
                           input logic [31:0] nco, input logic [6:0] g);
    logic [19:0] p;
    logic [7:0] o;
    bit ser, cx;
    ser = (ln != 0); cx = (dc == 2);
    nexp = 0;
    case (ln)
      0: push(8'h07, rs == 0 ? 8'hA9 : 8'h4B);
      1: push(8'h07, (rs == 0 || rs == 2) ? 8'h2B : 8'h4B);
      2: push(8'h07, 8'h6C);
      default: push(8'h07, 8'h8D);
    endcase
    push(8'h13, 8'h01);
    push(8'h13, 8'h00);
    if (ser) push(8'h18, 8'h10);
    if (ser) begin
      if (!cx) push(8'h19, ln == 1 ? 8'h10 : 8'h00);
      else push(8'h19, ln == 3 ? 8'h01 : 8'h80);
    end
    push(8'h1B, 8'(rs * 8));
    if (ser) push(8'h1F, 8'h50);
    p = 0;
    if (dc == 1 && ln == 2) p = (rs == 0) ? 20'hFE000 : (rs == 1) ? 20'hFF000 :
                                (rs == 2) ? 20'hFF800 : 20'hFFC00;
    if (cx && (ln == 1 || ln == 2)) p = 20'hFFFFF;
    if (p != 0) begin
      push(8'h20, p[7:0]); push(8'h21, p[15:8]); push(8'h22, {4'h0, p[19:16]});
    end
    push(8'h24, dc != 0 ? 8'h01 : 8'h00);
    push(8'h25, cfg);
    if (cx) begin
      for (int i = 0; i < 4; i++) push(8'h2A + 8'(i), nco[8*i +: 8]);
      for (int i = 0; i < 4; i++) push(8'h31 + 8'(i), nco[8*i +: 8]);
    end
    if (dc != 0) begin
      o = 8'h00;
      if (cx) o = (ln == 1) ? 8'h10 : (ln == 2) ? 8'h08 : (ln == 3) ? 8'h18 : 8'h00;
      push(8'h27, o); push(8'h2E, o);
    end
    push(8'h26, {g, 1'b0}); push(8'h26, {g, 1'b1}); push(8'h26, {g, 1'b0});
  endtask

  task automatic launch(input int ln, input int rs, input int dc, input logic [7:0] cfg,
                        input logic [31:0] nco, input logic [6:0] g);
    @(negedge clk);
    lane_mode = 2'(ln); res_code = 2'(rs); dec_mode = 2'(dc);
    dec_cfg = cfg; nco_word = nco; mix_gain = g; nlog = 0;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic await_end();
    for (int n = 0; n < 2000 && !done && !cfg_err; n++) @(negedge clk);
  endtask

  task automatic compare_log(input string name);
    bit ok;
    int gap;
    ok = (nlog == nexp);
    check(ok, "R11", {name, " write count"}, nlog, nexp);
    for (int i = 0; i < nexp && i < nlog; i++) begin
      if (la[i] !== ea[i] || ld[i] !== ed[i])
        check(0, tag_of(ea[i]), {name, " write addr/data"}, {la[i], ld[i]}, {ea[i], ed[i]});
    end
    if (nlog >= 3) begin
      gap = lt[2] - lt[1];
      check(gap >= WAITC && gap < WAITC + 10, "R3", {name, " pause cycles"}, gap, WAITC);
    end
    check(done && !busy && !cfg_err, "R11", {name, " done/busy"}, {done, busy, cfg_err}, 3'b100);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!wr_req && !busy && !done && !cfg_err, "R12", "reset outputs",
          {wr_req, busy, done, cfg_err}, 0);
  endtask

  task automatic t_all_legal();
    string nm;
    for (int ln = 0; ln < 4; ln++)
      for (int rs = 0; rs < 4; rs++)
        for (int dc = 0; dc < 3; dc++) begin
          if (ln == 0 && rs >= 2) continue;
          nm = $sformatf("lane%0d res%0d dec%0d", ln, rs, dc);
          build_exp(ln, rs, dc, 8'(8'h5A ^ (ln*16 + rs*4 + dc)), 32'h8765_4321 + 32'(rs),
                    7'(ln*8 + dc + 3));
          launch(ln, rs, dc, 8'(8'h5A ^ (ln*16 + rs*4 + dc)), 32'h8765_4321 + 32'(rs),
                 7'(ln*8 + dc + 3));
          await_end();
          compare_log(nm);
        end
  endtask

  task automatic t_illegal(input int ln, input int rs, input int dc);
    launch(ln, rs, dc, 8'h11, 32'h1, 7'h1);
    check(cfg_err && !busy && !done, "R1", "illegal flags", {cfg_err, busy, done}, 3'b100);
    repeat (20) @(negedge clk);
    check(nlog == 0, "R1", "illegal write count", nlog, 0);
  endtask

  task automatic t_busy_ignore();
    build_exp(2, 1, 2, 8'hC3, 32'hA1B2C3D4, 7'h2A);
    launch(2, 1, 2, 8'hC3, 32'hA1B2C3D4, 7'h2A);
    repeat (5) @(negedge clk);
    lane_mode = 0; res_code = 3; dec_mode = 1; dec_cfg = 8'hEE; start = 1;
    @(negedge clk);
    start = 0;
    check(!cfg_err && busy, "R13", "start while busy", {cfg_err, busy}, 2'b01);
    await_end();
    compare_log("R13 busy restart");
    repeat (10) @(negedge clk);
    check(done, "R13", "done held", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_illegal(0, 2, 1);
    t_illegal(0, 3, 0);
    t_illegal(1, 0, 3);
    t_all_legal();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule